// File: doc/BRIEF.md
# LUT-Backed Distributed Memory and Tapped Shift Register

This block reuses one 64-bit storage array in four ways, chosen by a two-bit mode input. It can act as a 64-entry by 1-bit RAM or as a 32-entry by 2-bit RAM. It can act as a single shift register of 32 stages with a selectable output tap. It can also act as two 16-stage shift registers that share one tap address but take separate serial inputs. Writes and shifts happen on the rising clock edge while the enable is high. The data output is decoded combinationally from the current address, so a read needs no clock.

A cascade output always carries array bit 31. In single shift mode that bit is the oldest stage. Wiring the cascade output of one cell to the serial input of the next gives longer delay lines: four cells give 128 stages. A synchronous reset clears the whole array. Mode encodings are `00` 64x1 RAM, `01` 32x2 RAM, `10` 32-stage shift register, `11` dual 16-stage shift register.

Top module: `lut_store`

## Requirements
- R1: While `rst` is high at a rising edge, all 64 array bits clear, so afterwards `dout` reads `00` at every address in every mode and `cascade_out` is 0.
- R2: In mode `00`, a rising edge with `we` high stores `din[0]` at the bit selected by all six `addr` bits; `dout[0]` shows the bit at `addr` and `dout[1]` is 0.
- R3: In mode `01`, `addr[4:0]` selects one of 32 two-bit words, `addr[5]` is ignored, a write stores both bits of `din`, and `dout` returns both stored bits.
- R4: In mode `10`, each rising edge with `we` high moves every stage up by one and loads `din[0]` into stage 0.
- R5: In mode `10`, `dout[0]` is the stage picked by `addr[4:0]` (0 is the newest input), `addr[5]` is ignored and `dout[1]` is 0.
- R6: `cascade_out` equals array bit 31 in every mode. In mode `10` this is stage 31, the `din[0]` value loaded 32 enabled shifts earlier. In mode `00` it is RAM bit 31, and in mode `01` it is bit 0 of word 31.
- R7: In mode `11`, `din[0]` feeds chain A and `din[1]` feeds chain B, each 16 stages long. Both chains shift on the same enabled edge. `addr[3:0]` taps both chains and `dout` is {chain B tap, chain A tap}. `cascade_out` is chain B stage 15.
- R8: A rising edge with `we` low changes no stored bit in any mode, whatever `din` holds.
- R9: `dout` follows a change of `addr` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous clear of the array, active high |
| mode | input | 2 | Storage organisation selector |
| we | input | 1 | Write enable in RAM modes, shift enable in shift modes |
| addr | input | 6 | RAM address or shift tap select |
| din | input | 2 | Write data or serial inputs |
| dout | output | 2 | Combinational read or tap data |
| cascade_out | output | 1 | Array bit 31, the serial output for chaining cells |

## Verification
The bound checker watches every clock for the local cycle rules. These are: a RAM write read back at an unchanged address, the newest stage appearing at tap 0 in both shift modes, stage 30 becoming the cascade output one shift later, a clear after reset, and contents holding when `we` is low. Whole-array behaviour can only be shown by the bench scenarios. Examples are every address holding its own value after a full sweep, `addr[5]` being ignored in the narrower modes, and the cascade carrying an input exactly 32 shifts old. The bench covers these with exhaustive address and tap sweeps against arithmetic expectations.

// File: rtl/lut_store.sv
module lut_store #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        din,
  output logic [1:0]        dout,
  output logic              cascade_out
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HALF  = DEPTH / 2;
  localparam int QUART = DEPTH / 4;
  localparam int HAW   = ADDR_W - 1;
  localparam int QAW   = ADDR_W - 2;

  localparam logic [1:0] M_RAM1  = 2'd0;
  localparam logic [1:0] M_RAM2  = 2'd1;
  localparam logic [1:0] M_SHIFT = 2'd2;

  logic [DEPTH-1:0] mem, nxt;
  wire  [HAW-1:0]   a_half  = addr[HAW-1:0];
  wire  [QAW-1:0]   a_quart = addr[QAW-1:0];

  always_comb begin
    nxt = mem;
    if (we) begin
      case (mode)
        M_RAM1:  nxt[addr] = din[0];
        M_RAM2: begin
          nxt[{1'b0, a_half}] = din[0];
          nxt[{1'b1, a_half}] = din[1];
        end
        M_SHIFT: nxt[HALF-1:0] = {mem[HALF-2:0], din[0]};
        default: begin
          nxt[QUART-1:0]    = {mem[QUART-2:0], din[0]};
          nxt[HALF-1:QUART] = {mem[HALF-2:QUART], din[1]};
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mem <= '0;
    else     mem <= nxt;
  end

  always_comb begin
    case (mode)
      M_RAM1:  dout = {1'b0, mem[addr]};
      M_RAM2:  dout = {mem[{1'b1, a_half}], mem[{1'b0, a_half}]};
      M_SHIFT: dout = {1'b0, mem[{1'b0, a_half}]};
      default: dout = {mem[{2'b01, a_quart}], mem[{2'b00, a_quart}]};
    endcase
  end

  assign cascade_out = mem[HALF-1];
endmodule

// File: rtl/lut_store_chk.sv
module lut_store_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        mode,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        din,
  input logic [1:0]        dout,
  input logic              cascade_out
);
  localparam int HAW = ADDR_W - 1;
  localparam int QAW = ADDR_W - 2;
  localparam logic [HAW-1:0] TAP30 = HAW'((1 << HAW) - 2);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (dout == 2'b00 && !cascade_out));

  p_ram1_write_r2: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0 && we) |=>
      (mode != 2'd0 || addr != $past(addr) || dout == {1'b0, $past(din[0])}));

  p_ram2_write_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1 && we) |=>
      (mode != 2'd1 || addr[HAW-1:0] != $past(addr[HAW-1:0]) || dout == $past(din)));

  p_shift_tap0_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2 && we) |=>
      (mode != 2'd2 || addr[HAW-1:0] != '0 || dout == {1'b0, $past(din[0])}));

  p_cascade_step_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2 && we && addr[HAW-1:0] == TAP30) |=> cascade_out == $past(dout[0]));

  p_dual_tap0_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd3 && we) |=>
      (mode != 2'd3 || addr[QAW-1:0] != '0 || dout == $past(din)));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !we |=> ($stable(cascade_out) &&
             (mode != $past(mode) || addr != $past(addr) || $stable(dout))));
endmodule

bind lut_store lut_store_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/lut_store_bench.sv
`timescale 1ns/1ps
module lut_store_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] mode;
  logic       we;
  logic [5:0] addr;
  logic [1:0] din;
  logic [1:0] dout;
  logic       cascade_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit ram[64];
  bit lo[32];
  bit hi[32];
  bit sr[32];
  bit ca[16];
  bit cb[16];
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  lut_store u_lut_store (
    .clk(clk), .rst(rst), .mode(mode), .we(we), .addr(addr),
    .din(din), .dout(dout), .cascade_out(cascade_out)
  );

  function automatic bit pat(input int a, input int s);
    return bit'(((a * 13 + s) >> 2) ^ a ^ (a >> 3));
  endfunction

  function automatic logic [1:0] rnd2();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[1:0];
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [1:0] got, input logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    rst = 1'b1; we = 1'b0; mode = m; din = 2'b00; addr = '0;
    tick(); tick();
    rst = 1'b0;
  endtask

  initial begin
    do_reset(2'd0);
    // R1: array clear after reset
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      for (int a = 0; a < 64; a += 5) begin
        addr = 6'(a); #1;
        chk("R1 dout", dout, 2'b00);
      end
      chk("R1 cascade", {1'b0, cascade_out}, 2'b00);
    end

    // R2: 64x1 write sweep then read sweep
    do_reset(2'd0);
    for (int a = 0; a < 64; a++) begin
      we = 1'b1; addr = 6'(a); din = {1'b1, pat(a, 7)};
      tick();
      ram[a] = pat(a, 7);
    end
    we = 1'b0;
    for (int a = 63; a >= 0; a--) begin
      addr = 6'(a); #1;
      chk("R2/R9 ram64 read", dout, {1'b0, ram[a]});
    end
    chk("R6 cascade ram64", {1'b0, cascade_out}, {1'b0, ram[31]});
    // R8: clocks with we low and inverted data
    for (int a = 0; a < 64; a++) begin
      addr = 6'(a); din = {1'b0, ~ram[a]};
      tick();
    end
    for (int a = 0; a < 64; a += 3) begin
      addr = 6'(a); #1;
      chk("R8 ram64 hold", dout, {1'b0, ram[a]});
    end

    // R3: 32x2 with addr[5] toggled between write and read
    do_reset(2'd1);
    for (int a = 0; a < 32; a++) begin
      we = 1'b1; addr = {1'(a & 1), 5'(a)}; din = {pat(a, 3), pat(a, 11)};
      tick();
      hi[a] = pat(a, 3); lo[a] = pat(a, 11);
    end
    we = 1'b0;
    for (int a = 0; a < 32; a++) begin
      addr = {1'(~a & 1), 5'(a)}; #1;
      chk("R3 ram32x2 read", dout, {hi[a], lo[a]});
    end
    chk("R6 cascade ram32x2", {1'b0, cascade_out}, {1'b0, lo[31]});

    // R4 R5 R6: single 32-stage shift register
    do_reset(2'd2);
    for (int i = 0; i < 32; i++) sr[i] = 1'b0;
    for (int k = 0; k < 45; k++) begin
      logic [1:0] r;
      r = rnd2();
      we = 1'b1; din = r; addr = {1'(k & 1), 5'(k * 7)};
      tick();
      for (int i = 31; i > 0; i--) sr[i] = sr[i-1];
      sr[0] = r[0];
      we = 1'b0; #1;
      chk("R4/R5 shift tap", dout, {1'b0, sr[(k * 7) % 32]});
      chk("R6 cascade shift", {1'b0, cascade_out}, {1'b0, sr[31]});
    end
    for (int t = 0; t < 32; t++) begin
      addr = {1'(t >> 2), 5'(t)}; #1;
      chk("R5 tap sweep", dout, {1'b0, sr[t]});
    end
    for (int k = 0; k < 5; k++) begin
      din = 2'b11; addr = 6'(k);
      tick();
    end
    for (int t = 0; t < 32; t++) begin
      addr = 6'(t); #1;
      chk("R8 shift hold", dout, {1'b0, sr[t]});
    end

    // R7: dual 16-stage chains
    do_reset(2'd3);
    for (int i = 0; i < 16; i++) begin ca[i] = 1'b0; cb[i] = 1'b0; end
    for (int k = 0; k < 22; k++) begin
      logic [1:0] r;
      r = rnd2();
      we = 1'b1; din = r; addr = 6'(k * 5);
      tick();
      for (int i = 15; i > 0; i--) begin ca[i] = ca[i-1]; cb[i] = cb[i-1]; end
      ca[0] = r[0]; cb[0] = r[1];
      we = 1'b0;
      for (int t = 0; t < 16; t++) begin
        addr = {2'(k), 4'(t)}; #1;
        chk("R7 dual tap", dout, {cb[t], ca[t]});
      end
      chk("R7 dual cascade", {1'b0, cascade_out}, {1'b0, cb[15]});
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule